// File: doc/BRIEF.md
# SMRAM window access controller

This block sits on the memory request path in front of two memories: a dedicated SMRAM and ordinary system RAM. Each request carries an address, a read/write flag, write data and a flag that says whether the requester is in system management mode (SMM). The block steers each request to one of three targets: SMRAM, normal RAM, or a black hole. A request goes to SMRAM or the black hole only when its address falls inside a fixed 128 KiB protected window from 0x30000 to 0x4FFFF.

The window has three states: closed, open and locked. A small command port changes the state. It accepts explicit open, close and lock commands, and a "step" command.
- The first step maps the window.
- A second step unmaps and locks it.
- Once locked, only a hardware reset releases the window.
- Normal-mode code never sees RAM behind the window. When the window is not mapped, such accesses land in the black hole.
- Black-hole accesses complete locally: reads return all-ones and writes are dropped.

The block also watches I/O writes. A write to port 0xB2 produces a one-cycle broadcast SMI pulse.

Top module: `smram_gate`

## Requirements
- R1: A request whose address lies outside 0x30000..0x4FFFF (both ends inclusive in the window) is steered to normal RAM in every state and for both requester modes.
- R2: While the window is open, in-window requests from both SMM and normal-mode requesters are steered to SMRAM.
- R3: While the window is closed or locked, in-window normal-mode requests are steered to the black hole, and in-window SMM requests are steered to SMRAM.
- R4: After reset the window is closed and unlocked, the violation flag is clear, and no SMI pulse or black-hole completion is present.
- R5: Command code 2'b00 (step) moves a closed window to open and an open window to locked. The new state is visible one cycle after the command.
- R6: Command code 2'b01 opens the window, 2'b10 closes it, and 2'b11 closes and locks it. Each takes effect one cycle after the command.
- R7: While locked, every command is ignored and sets a sticky violation flag. Only reset clears the lock and the flag.
- R8: A black-hole request gets a completion one cycle later. A read completion carries all-ones data. A write completion is flagged as a write, carries zero data, and its data is discarded.
- R9: An I/O write to port 0xB2 gives exactly one SMI pulse one cycle later. I/O reads of that port and writes to other ports give none.
- R10: Exactly one steering output is high for each valid request, and none is high when there is no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| req_valid | input | 1 | Memory request present |
| req_addr | input | 32 | Request address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data |
| req_smm | input | 1 | Requester is in system management mode |
| cfg_valid | input | 1 | Window command strobe |
| cfg_cmd | input | 2 | 00 step, 01 open, 10 close, 11 lock |
| io_valid | input | 1 | I/O access present |
| io_write | input | 1 | I/O access is a write |
| io_port | input | 16 | I/O port number |
| sel_smram | output | 1 | Request steered to SMRAM |
| sel_ram | output | 1 | Request steered to normal RAM |
| sel_hole | output | 1 | Request absorbed by the black hole |
| fwd_addr | output | 32 | Address forwarded to the selected memory |
| fwd_wdata | output | 32 | Write data forwarded to the selected memory |
| fwd_write | output | 1 | Write flag forwarded to the selected memory |
| hole_resp_valid | output | 1 | Black-hole completion |
| hole_resp_write | output | 1 | Completion belongs to a write |
| hole_rdata | output | 32 | Black-hole read data |
| win_open | output | 1 | Window currently open |
| win_locked | output | 1 | Window locked |
| lock_violation | output | 1 | Sticky: command seen while locked |
| smi_pulse | output | 1 | Broadcast SMI request pulse |

## Verification
The steering outputs and the forwarded fields are combinational. The bench reads them in the same cycle as the request, two nanoseconds after it drives the inputs on a falling edge.

Three kinds of result pass through one register and are due one cycle later:
- black-hole completions;
- window state changes after a command;
- the SMI pulse.

The bench samples each of these on the next falling edge. It samples the pulse again on the falling edge after that, to confirm it lasts one cycle. Checks that a locked command was ignored read `win_open` and `win_locked` one cycle after the command, and also issue a normal-mode in-window request to confirm it still reaches the black hole.

// File: rtl/smram_gate_pkg.sv
package smram_gate_pkg;

    typedef enum logic [1:0] {
        WIN_CLOSED = 2'd0,
        WIN_OPEN   = 2'd1,
        WIN_LOCKED = 2'd2
    } win_state_e;

    localparam logic [1:0] CMD_STEP  = 2'b00;
    localparam logic [1:0] CMD_OPEN  = 2'b01;
    localparam logic [1:0] CMD_CLOSE = 2'b10;
    localparam logic [1:0] CMD_LOCK  = 2'b11;

    typedef struct packed {
        win_state_e state;
        logic       viol;
    } win_ctrl_t;

    typedef struct packed {
        logic vld;
        logic wr;
    } hole_resp_t;

endpackage

// File: rtl/smram_win_decode.sv
module smram_win_decode #(
    parameter int unsigned        ADDR_W   = 32,
    parameter logic [ADDR_W-1:0]  WIN_BASE = 'h30000,
    parameter logic [ADDR_W-1:0]  WIN_SIZE = 'h20000
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              in_win
);
    localparam logic [ADDR_W-1:0] WIN_LAST = WIN_BASE + WIN_SIZE - 1'b1;

    always_comb begin
        in_win = (addr >= WIN_BASE) && (addr <= WIN_LAST);
    end
endmodule

// File: rtl/smram_win_ctrl.sv
module smram_win_ctrl
    import smram_gate_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_valid,
    input  logic [1:0] cfg_cmd,
    output win_state_e state,
    output logic       viol
);
    win_ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d = ctrl_q;
        if (cfg_valid) begin
            if (ctrl_q.state == WIN_LOCKED) begin
                ctrl_d.viol = 1'b1;
            end else begin
                case (cfg_cmd)
                    CMD_STEP:  ctrl_d.state = (ctrl_q.state == WIN_OPEN) ? WIN_LOCKED : WIN_OPEN;
                    CMD_OPEN:  ctrl_d.state = WIN_OPEN;
                    CMD_CLOSE: ctrl_d.state = WIN_CLOSED;
                    default:   ctrl_d.state = WIN_LOCKED;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '{state: WIN_CLOSED, viol: 1'b0};
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign state = ctrl_q.state;
    assign viol  = ctrl_q.viol;
endmodule

// File: rtl/smram_smi_trig.sv
module smram_smi_trig #(
    parameter int unsigned       PORT_W   = 16,
    parameter logic [PORT_W-1:0] SMI_PORT = 'hB2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_valid,
    input  logic              io_write,
    input  logic [PORT_W-1:0] io_port,
    output logic              smi_pulse
);
    logic pulse_d, pulse_q;

    always_comb begin
        pulse_d = io_valid && io_write && (io_port == SMI_PORT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= pulse_d;
        end
    end

    assign smi_pulse = pulse_q;
endmodule

// File: rtl/smram_gate.sv
module smram_gate
    import smram_gate_pkg::*;
#(
    parameter int unsigned        ADDR_W   = 32,
    parameter int unsigned        DATA_W   = 32,
    parameter int unsigned        PORT_W   = 16,
    parameter logic [ADDR_W-1:0]  WIN_BASE = 'h30000,
    parameter logic [ADDR_W-1:0]  WIN_SIZE = 'h20000,
    parameter logic [PORT_W-1:0]  SMI_PORT = 'hB2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_smm,
    input  logic              cfg_valid,
    input  logic [1:0]        cfg_cmd,
    input  logic              io_valid,
    input  logic              io_write,
    input  logic [PORT_W-1:0] io_port,
    output logic              sel_smram,
    output logic              sel_ram,
    output logic              sel_hole,
    output logic [ADDR_W-1:0] fwd_addr,
    output logic [DATA_W-1:0] fwd_wdata,
    output logic              fwd_write,
    output logic              hole_resp_valid,
    output logic              hole_resp_write,
    output logic [DATA_W-1:0] hole_rdata,
    output logic              win_open,
    output logic              win_locked,
    output logic              lock_violation,
    output logic              smi_pulse
);
    logic       in_win;
    win_state_e win_state;
    logic       viol;
    hole_resp_t resp_d, resp_q;

    smram_win_decode #(
        .ADDR_W  (ADDR_W),
        .WIN_BASE(WIN_BASE),
        .WIN_SIZE(WIN_SIZE)
    ) u_decode (
        .addr  (req_addr),
        .in_win(in_win)
    );

    smram_win_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_valid(cfg_valid),
        .cfg_cmd  (cfg_cmd),
        .state    (win_state),
        .viol     (viol)
    );

    smram_smi_trig #(
        .PORT_W  (PORT_W),
        .SMI_PORT(SMI_PORT)
    ) u_trig (
        .clk      (clk),
        .rst_n    (rst_n),
        .io_valid (io_valid),
        .io_write (io_write),
        .io_port  (io_port),
        .smi_pulse(smi_pulse)
    );

    // Steering: outside -> RAM; inside -> SMRAM when open or SMM, else hole.
    always_comb begin
        sel_smram = 1'b0;
        sel_ram   = 1'b0;
        sel_hole  = 1'b0;
        if (req_valid) begin
            if (!in_win) begin
                sel_ram = 1'b1;
            end else if ((win_state == WIN_OPEN) || req_smm) begin
                sel_smram = 1'b1;
            end else begin
                sel_hole = 1'b1;
            end
        end
    end

    assign fwd_addr  = req_addr;
    assign fwd_wdata = req_wdata;
    assign fwd_write = req_write;

    always_comb begin
        resp_d.vld = sel_hole;
        resp_d.wr  = sel_hole && req_write;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            resp_q <= '0;
        end else begin
            resp_q <= resp_d;
        end
    end

    assign hole_resp_valid = resp_q.vld;
    assign hole_resp_write = resp_q.wr;
    assign hole_rdata      = (resp_q.vld && !resp_q.wr) ? {DATA_W{1'b1}} : '0;
    assign win_open        = (win_state == WIN_OPEN);
    assign win_locked      = (win_state == WIN_LOCKED);
    assign lock_violation  = viol;
endmodule

// File: rtl/smram_gate_chk.sv
module smram_gate_chk #(
    parameter int unsigned        ADDR_W   = 32,
    parameter logic [ADDR_W-1:0]  WIN_BASE = 'h30000,
    parameter logic [ADDR_W-1:0]  WIN_SIZE = 'h20000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [ADDR_W-1:0] req_addr,
    input logic              req_smm,
    input logic              sel_smram,
    input logic              sel_ram,
    input logic              sel_hole,
    input logic              hole_resp_valid,
    input logic              win_open,
    input logic              win_locked,
    input logic              lock_violation,
    input logic              smi_pulse
);
    localparam logic [ADDR_W-1:0] LAST = WIN_BASE + WIN_SIZE - 1'b1;
    logic outside;
    assign outside = (req_addr < WIN_BASE) || (req_addr > LAST);

    p_outside_ram_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && outside) |-> sel_ram);

    p_open_smram_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !outside && win_open) |-> sel_smram);

    p_closed_smm_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !outside && !win_open && req_smm) |-> sel_smram);

    p_closed_hole_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !outside && !win_open && !req_smm) |-> sel_hole);

    p_lock_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        win_locked |=> win_locked);

    p_viol_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        lock_violation |=> lock_violation);

    p_locked_closed_r7: assert property (@(posedge clk) disable iff (!rst_n)
        win_locked |-> !win_open);

    p_hole_resp_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sel_hole |=> hole_resp_valid);

    p_smi_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        smi_pulse |=> !smi_pulse);

    p_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> ($countones({sel_smram, sel_ram, sel_hole}) == 1));

    p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> !(sel_smram || sel_ram || sel_hole));
endmodule

bind smram_gate smram_gate_chk #(
    .ADDR_W  (ADDR_W),
    .WIN_BASE(WIN_BASE),
    .WIN_SIZE(WIN_SIZE)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_addr       (req_addr),
    .req_smm        (req_smm),
    .sel_smram      (sel_smram),
    .sel_ram        (sel_ram),
    .sel_hole       (sel_hole),
    .hole_resp_valid(hole_resp_valid),
    .win_open       (win_open),
    .win_locked     (win_locked),
    .lock_violation (lock_violation),
    .smi_pulse      (smi_pulse)
);

// File: tb/smram_gate_bench.sv
`timescale 1ns/1ps
module smram_gate_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic [31:0] req_wdata = '0;
    logic        req_smm = 1'b0;
    logic        cfg_valid = 1'b0;
    logic [1:0]  cfg_cmd = 2'b00;
    logic        io_valid = 1'b0;
    logic        io_write = 1'b0;
    logic [15:0] io_port = '0;
    logic        sel_smram, sel_ram, sel_hole;
    logic [31:0] fwd_addr, fwd_wdata;
    logic        fwd_write;
    logic        hole_resp_valid, hole_resp_write;
    logic [31:0] hole_rdata;
    logic        win_open, win_locked, lock_violation, smi_pulse;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    localparam logic [2:0] TO_SMRAM = 3'b100;
    localparam logic [2:0] TO_RAM   = 3'b010;
    localparam logic [2:0] TO_HOLE  = 3'b001;

    always #4 clk = ~clk;

    smram_gate u_smram_gate (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write),
        .req_wdata(req_wdata), .req_smm(req_smm),
        .cfg_valid(cfg_valid), .cfg_cmd(cfg_cmd),
        .io_valid(io_valid), .io_write(io_write), .io_port(io_port),
        .sel_smram(sel_smram), .sel_ram(sel_ram), .sel_hole(sel_hole),
        .fwd_addr(fwd_addr), .fwd_wdata(fwd_wdata), .fwd_write(fwd_write),
        .hole_resp_valid(hole_resp_valid), .hole_resp_write(hole_resp_write),
        .hole_rdata(hole_rdata),
        .win_open(win_open), .win_locked(win_locked),
        .lock_violation(lock_violation), .smi_pulse(smi_pulse)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic send_cmd(input logic [1:0] cmd);
        @(negedge clk);
        cfg_valid = 1'b1;
        cfg_cmd   = cmd;
        @(negedge clk);
        cfg_valid = 1'b0;
    endtask

    // Request: steering checked in the same cycle, hole completion one cycle later.
    task automatic access(input string tag, input logic [31:0] addr, input logic wr,
                          input logic smm, input logic [2:0] exp_sel);
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = addr;
        req_write = wr;
        req_wdata = addr ^ 32'h5A5A_0000;
        req_smm   = smm;
        #2;
        chk({tag, " steer"}, {61'd0, sel_smram, sel_ram, sel_hole}, {61'd0, exp_sel});
        chk({tag, " fwd_addr"}, {32'd0, fwd_addr}, {32'd0, addr});
        @(negedge clk);
        req_valid = 1'b0;
        chk({tag, " R8 hole completion"}, {63'd0, hole_resp_valid}, {63'd0, exp_sel == TO_HOLE});
        if (exp_sel == TO_HOLE) begin
            chk({tag, " R8 completion type"}, {63'd0, hole_resp_write}, {63'd0, wr});
            chk({tag, " R8 hole data"}, {32'd0, hole_rdata}, wr ? 64'd0 : 64'hFFFF_FFFF);
        end
    endtask

    task automatic t_reset_state();
        chk("R4 win_open", {63'd0, win_open}, 64'd0);
        chk("R4 win_locked", {63'd0, win_locked}, 64'd0);
        chk("R4 violation", {63'd0, lock_violation}, 64'd0);
        chk("R4 smi", {63'd0, smi_pulse}, 64'd0);
        chk("R4 hole resp", {63'd0, hole_resp_valid}, 64'd0);
        chk("R10 idle steer", {61'd0, sel_smram, sel_ram, sel_hole}, 64'd0);
    endtask

    task automatic t_outside();
        access("R1 below window", 32'h0002_FFFF, 1'b0, 1'b0, TO_RAM);
        access("R1 above window smm", 32'h0005_0000, 1'b1, 1'b1, TO_RAM);
        access("R1 zero addr", 32'h0000_0000, 1'b0, 1'b1, TO_RAM);
        access("R1 high addr", 32'hFFFF_0000, 1'b1, 1'b0, TO_RAM);
    endtask

    task automatic t_closed();
        access("R3 closed base read", 32'h0003_0000, 1'b0, 1'b0, TO_HOLE);
        access("R3 closed last write", 32'h0004_FFFF, 1'b1, 1'b0, TO_HOLE);
        access("R3 closed smm read", 32'h0004_0000, 1'b0, 1'b1, TO_SMRAM);
        access("R3 closed smm write", 32'h0003_1234, 1'b1, 1'b1, TO_SMRAM);
    endtask

    task automatic t_explicit_cmds();
        send_cmd(2'b01);
        chk("R6 open cmd", {62'd0, win_open, win_locked}, 64'b10);
        access("R2 open normal read", 32'h0003_8000, 1'b0, 1'b0, TO_SMRAM);
        access("R2 open smm write", 32'h0004_FFFF, 1'b1, 1'b1, TO_SMRAM);
        access("R1 open outside", 32'h0005_0000, 1'b0, 1'b0, TO_RAM);
        send_cmd(2'b10);
        chk("R6 close cmd", {62'd0, win_open, win_locked}, 64'b00);
        access("R3 after close", 32'h0003_0000, 1'b0, 1'b0, TO_HOLE);
    endtask

    task automatic t_step_sequence();
        send_cmd(2'b00);
        chk("R5 first step opens", {62'd0, win_open, win_locked}, 64'b10);
        send_cmd(2'b00);
        chk("R5 second step locks", {62'd0, win_open, win_locked}, 64'b01);
        chk("R7 no violation yet", {63'd0, lock_violation}, 64'd0);
        access("R3 locked normal", 32'h0003_0010, 1'b0, 1'b0, TO_HOLE);
        access("R3 locked smm", 32'h0003_0010, 1'b0, 1'b1, TO_SMRAM);
    endtask

    task automatic t_locked_ignored();
        send_cmd(2'b01);
        chk("R7 open ignored", {62'd0, win_open, win_locked}, 64'b01);
        chk("R7 violation set", {63'd0, lock_violation}, 64'd1);
        access("R7 still hole", 32'h0004_0000, 1'b0, 1'b0, TO_HOLE);
        send_cmd(2'b10);
        chk("R7 close ignored", {62'd0, win_open, win_locked}, 64'b01);
        send_cmd(2'b00);
        chk("R7 step ignored", {62'd0, win_open, win_locked}, 64'b01);
        repeat (3) @(negedge clk);
        chk("R7 violation sticky", {63'd0, lock_violation}, 64'd1);
        do_reset();
        chk("R7 reset unlocks", {62'd0, win_open, win_locked}, 64'b00);
        chk("R7 reset clears violation", {63'd0, lock_violation}, 64'd0);
        send_cmd(2'b11);
        chk("R6 lock cmd", {62'd0, win_open, win_locked}, 64'b01);
        chk("R6 lock no violation", {63'd0, lock_violation}, 64'd0);
    endtask

    task automatic t_smi();
        @(negedge clk);
        io_valid = 1'b1; io_write = 1'b1; io_port = 16'h00B2;
        @(negedge clk);
        io_valid = 1'b0;
        chk("R9 pulse after write", {63'd0, smi_pulse}, 64'd1);
        @(negedge clk);
        chk("R9 pulse one cycle", {63'd0, smi_pulse}, 64'd0);
        io_valid = 1'b1; io_write = 1'b0; io_port = 16'h00B2;
        @(negedge clk);
        io_valid = 1'b0;
        chk("R9 read no pulse", {63'd0, smi_pulse}, 64'd0);
        io_valid = 1'b1; io_write = 1'b1; io_port = 16'h00B3;
        @(negedge clk);
        io_valid = 1'b0;
        chk("R9 other port no pulse", {63'd0, smi_pulse}, 64'd0);
    endtask

    initial begin
        do_reset();
        t_reset_state();
        t_outside();
        t_closed();
        t_explicit_cmds();
        t_smi();
        t_step_sequence();
        t_locked_ignored();
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule